// File: doc/BRIEF.md
# ECAM Configuration Address Translator

This block sits on the outbound side of a PCIe root port. A processor-side memory read or write that lands in the enhanced configuration window is turned into a configuration request descriptor: a 16-bit bus/device/function identifier, a dword register number, byte enables, the request direction, and a Type 0 / Type 1 flag. Accesses that fall in the first 1 MiB of the window belong to bus 0, the root port itself. They are sent to a local register port with their window-relative offset and are never translated.

Translation is steered by a small set of outbound regions. Each region has a base, a size, a kind word and a control word, and all of them are loaded through a register write port. In a normal setup, region 0 covers window base + 1 MiB for 1 MiB and issues Type 0 requests. Region 1 starts at window base + 2 MiB, covers the remaining buses and issues Type 1 requests. When a region's shift control is set, address bits [27:12] become the identifier directly, so one region reaches every device on every bus behind it. Without shift, the region always targets the fixed identifier held in its kind word.

Shift is only accepted when the window base is 256 MiB aligned and the window holds at least as many 1 MiB bus slices as the programmed bus count. The window base, window size and bus count are also loaded through the register write port.

Top module: `ecam_xlat_top`

## Requirements
- R1: After reset every output is 0, every region is disabled, and the window registers are 0. Until it is configured, every aligned access therefore returns an unsupported-request error.
- R2: An access that hits an enabled region with shift active produces `cfg_bdf` = address[27:12] and `cfg_reg` = address[11:2]. These appear on the outputs one clock after `acc_valid`, with `cfg_write` copying `acc_write`.
- R3: `cfg_type1` equals bit 0 of the hitting region's kind word (0 = Type 0, 1 = Type 1).
- R4: An aligned access whose address lies in [window base, window base + 1 MiB) with a nonzero window size produces `loc_valid`, with `loc_offset` = address − window base, and no configuration request.
- R5: A hitting region without shift active produces `cfg_bdf` = bits [31:16] of its kind word, whatever the address.
- R6: A control-word write with bit 28 (shift) set stores bit 28 as 0 unless window base bits [27:0] are zero and (window size >> 20) ≥ bus count at the time of the write.
- R7: Byte enables follow `acc_size` and the address low bits. Size 0 (byte) gives 4'b0001 << addr[1:0]. Size 1 (half) gives 4'b0011 or 4'b1100, chosen by addr[1]. Size 2 or 3 (word) gives 4'b1111.
- R8: A half access with addr[0] = 1, or a word access with addr[1:0] ≠ 0, gives `err_valid` with `err_code` = 2. This takes priority over every other outcome.
- R9: An aligned access outside the local slice that hits no region with control bit 31 (enable) set gives `err_valid` with `err_code` = 1.
- R10: While a region's enable bit is set, writes to its base, size and kind are ignored. A control write is accepted only if it clears bit 31.
- R11: A register write takes effect from the next cycle. An access presented in the same cycle as an enabling write still sees the old state.
- R12: When enabled regions overlap, the lowest-index region translates the access.
- R13: Each accepted access produces exactly one of `cfg_valid`, `loc_valid` or `err_valid` one cycle later. In a cycle without an access, none of them is set.

Register select codes on `wr_sel`: 0 region base, 1 region size, 2 region kind, 3 region control, 4 window base, 5 window size, 6 window bus count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select code |
| wr_idx | input | IDX_W | Region index for region registers |
| wr_data | input | 32 | Register write data |
| acc_valid | input | 1 | Memory access present |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | 0 byte, 1 half, 2/3 word |
| cfg_valid | output | 1 | Configuration request issued |
| cfg_write | output | 1 | Request direction |
| cfg_type1 | output | 1 | 1 = Type 1, 0 = Type 0 |
| cfg_bdf | output | 16 | Bus/device/function identifier |
| cfg_reg | output | 10 | Dword register number |
| rsp_be | output | 4 | Byte enables for configuration or local access |
| loc_valid | output | 1 | Local (bus 0) register access |
| loc_offset | output | 20 | Offset inside the bus 0 slice |
| err_valid | output | 1 | Error response |
| err_code | output | 2 | 1 unsupported request, 2 misaligned |

## Verification
Each outcome (configuration request, local access or error) is registered and appears exactly one clock edge after the access is sampled. The bench drives every access on a falling edge and reads the result on the next falling edge, which is half a cycle after the single register stage has loaded. Register writes use the same timing. The same-cycle test for R11 holds the access for two cycles, so the old state is seen on the first result and the new state on the second. With no access present, the outputs return to zero on the next edge, and one check reads them there.

// File: rtl/ecam_xlat_pkg.sv
package ecam_xlat_pkg;
  localparam int AW          = 32;
  localparam int SLICE_SHIFT = 20;
  localparam int ALIGN_BITS  = 28;

  localparam int CTL_EN      = 31;
  localparam int CTL_BARMODE = 30;
  localparam int CTL_SHIFT   = 28;
  localparam int CTL_NOPAY   = 22;
  localparam int CTL_FNMATCH = 19;

  typedef enum logic [2:0] {
    SEL_RBASE = 3'd0,
    SEL_RSIZE = 3'd1,
    SEL_RKIND = 3'd2,
    SEL_RCTL  = 3'd3,
    SEL_WBASE = 3'd4,
    SEL_WSIZE = 3'd5,
    SEL_WBUS  = 3'd6
  } sel_e;

  typedef enum logic [1:0] {
    OUT_NONE = 2'd0,
    OUT_CFG  = 2'd1,
    OUT_LOC  = 2'd2,
    OUT_ERR  = 2'd3
  } out_e;

  localparam logic [1:0] ERR_UR    = 2'd1;
  localparam logic [1:0] ERR_ALIGN = 2'd2;

  typedef struct packed {
    logic [AW-1:0] base;
    logic [AW-1:0] size;
    logic [31:0]   kind;
    logic [31:0]   ctl;
  } region_t;
endpackage

// File: rtl/ecam_region_file.sv
module ecam_region_file
  import ecam_xlat_pkg::*;
#(
  parameter int NREG  = 2,
  parameter int IDX_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [31:0]       wr_data,
  output region_t           regs_o [NREG],
  output logic [AW-1:0]     win_base_o,
  output logic [AW-1:0]     win_size_o,
  output logic [31:0]       win_bus_o
);
  logic shift_ok;
  assign shift_ok = (win_base_o[ALIGN_BITS-1:0] == '0) &&
                    ((win_size_o >> SLICE_SHIFT) >= win_bus_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_base_o <= '0;
      win_size_o <= '0;
      win_bus_o  <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_WBASE: win_base_o <= wr_data;
        SEL_WSIZE: win_size_o <= wr_data;
        SEL_WBUS:  win_bus_o  <= wr_data;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic locked, mine;
    assign locked = regs_o[g].ctl[CTL_EN];
    assign mine   = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        regs_o[g] <= '0;
      end else if (mine) begin
        case (wr_sel)
          SEL_RBASE: if (!locked) regs_o[g].base <= wr_data;
          SEL_RSIZE: if (!locked) regs_o[g].size <= wr_data;
          SEL_RKIND: if (!locked) regs_o[g].kind <= wr_data;
          SEL_RCTL: if (!locked || !wr_data[CTL_EN]) begin
            regs_o[g].ctl <= wr_data;
            regs_o[g].ctl[CTL_SHIFT] <= wr_data[CTL_SHIFT] && shift_ok;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ecam_addr_decode.sv
module ecam_addr_decode
  import ecam_xlat_pkg::*;
#(
  parameter int NREG = 2
) (
  input  region_t        regs_i [NREG],
  input  logic [AW-1:0]  win_base_i,
  input  logic [AW-1:0]  win_size_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [1:0]     size_i,
  output out_e           kind_o,
  output logic [15:0]    bdf_o,
  output logic [9:0]     reg_o,
  output logic [3:0]     be_o,
  output logic           type1_o,
  output logic [SLICE_SHIFT-1:0] loc_off_o,
  output logic [1:0]     err_o
);
  localparam logic [AW:0] SLICE = (AW+1)'(1) << SLICE_SHIFT;

  logic [NREG-1:0] hit;
  for (genvar g = 0; g < NREG; g++) begin : g_hit
    logic [AW:0] lo, hi, a;
    assign a  = {1'b0, addr_i};
    assign lo = {1'b0, regs_i[g].base};
    assign hi = lo + {1'b0, regs_i[g].size};
    assign hit[g] = (a >= lo) && (a < hi) && regs_i[g].ctl[CTL_EN];
  end

  logic        misalign, in_local, found;
  logic [AW-1:0] diff;
  region_t     pick;

  assign diff     = addr_i - win_base_i;
  assign in_local = (win_size_i != '0) && (addr_i >= win_base_i) &&
                    ({1'b0, diff} < SLICE);
  assign misalign = (size_i == 2'd1 && addr_i[0]) ||
                    (size_i[1] && addr_i[1:0] != 2'b00);

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hit[i]) begin
        found = 1'b1;
        pick  = regs_i[i];
      end
    end
  end

  always_comb begin
    case (size_i)
      2'd0:    be_o = 4'b0001 << addr_i[1:0];
      2'd1:    be_o = addr_i[1] ? 4'b1100 : 4'b0011;
      default: be_o = 4'b1111;
    endcase
  end

  assign bdf_o     = pick.ctl[CTL_SHIFT] ? addr_i[27:12] : pick.kind[31:16];
  assign reg_o     = addr_i[11:2];
  assign type1_o   = pick.kind[0];
  assign loc_off_o = diff[SLICE_SHIFT-1:0];

  always_comb begin
    err_o = 2'd0;
    if (misalign) begin
      kind_o = OUT_ERR;
      err_o  = ERR_ALIGN;
    end else if (in_local) begin
      kind_o = OUT_LOC;
    end else if (found) begin
      kind_o = OUT_CFG;
    end else begin
      kind_o = OUT_ERR;
      err_o  = ERR_UR;
    end
  end
endmodule

// File: rtl/ecam_xlat_top.sv
module ecam_xlat_top
  import ecam_xlat_pkg::*;
#(
  parameter int NREG  = 2,
  parameter int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_data,
  input  logic             acc_valid,
  input  logic [31:0]      acc_addr,
  input  logic             acc_write,
  input  logic [1:0]       acc_size,
  output logic             cfg_valid,
  output logic             cfg_write,
  output logic             cfg_type1,
  output logic [15:0]      cfg_bdf,
  output logic [9:0]       cfg_reg,
  output logic [3:0]       rsp_be,
  output logic             loc_valid,
  output logic [19:0]      loc_offset,
  output logic             err_valid,
  output logic [1:0]       err_code
);
  region_t       regs [NREG];
  logic [AW-1:0] win_base, win_size;
  logic [31:0]   win_bus;

  out_e        d_kind;
  logic [15:0] d_bdf;
  logic [9:0]  d_reg;
  logic [3:0]  d_be;
  logic        d_t1;
  logic [SLICE_SHIFT-1:0] d_off;
  logic [1:0]  d_err;

  ecam_region_file #(.NREG(NREG), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .regs_o(regs), .win_base_o(win_base),
    .win_size_o(win_size), .win_bus_o(win_bus)
  );

  ecam_addr_decode #(.NREG(NREG)) u_dec (
    .regs_i(regs), .win_base_i(win_base), .win_size_i(win_size),
    .addr_i(acc_addr), .size_i(acc_size), .kind_o(d_kind), .bdf_o(d_bdf),
    .reg_o(d_reg), .be_o(d_be), .type1_o(d_t1), .loc_off_o(d_off),
    .err_o(d_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_valid  <= 1'b0;
      cfg_write  <= 1'b0;
      cfg_type1  <= 1'b0;
      cfg_bdf    <= '0;
      cfg_reg    <= '0;
      rsp_be     <= '0;
      loc_valid  <= 1'b0;
      loc_offset <= '0;
      err_valid  <= 1'b0;
      err_code   <= '0;
    end else begin
      cfg_valid  <= acc_valid && (d_kind == OUT_CFG);
      loc_valid  <= acc_valid && (d_kind == OUT_LOC);
      err_valid  <= acc_valid && (d_kind == OUT_ERR);
      cfg_write  <= acc_valid && acc_write;
      cfg_type1  <= acc_valid && (d_kind == OUT_CFG) && d_t1;
      cfg_bdf    <= (acc_valid && d_kind == OUT_CFG) ? d_bdf : '0;
      cfg_reg    <= (acc_valid && d_kind == OUT_CFG) ? d_reg : '0;
      rsp_be     <= (acc_valid && d_kind != OUT_ERR) ? d_be : '0;
      loc_offset <= (acc_valid && d_kind == OUT_LOC) ? d_off : '0;
      err_code   <= acc_valid ? d_err : '0;
    end
  end
endmodule

// File: rtl/ecam_xlat_chk.sv
module ecam_xlat_chk (
  input logic        clk,
  input logic        rst,
  input logic        acc_valid,
  input logic [31:0] acc_addr,
  input logic [1:0]  acc_size,
  input logic        cfg_valid,
  input logic [9:0]  cfg_reg,
  input logic [3:0]  rsp_be,
  input logic        loc_valid,
  input logic        err_valid,
  input logic [1:0]  err_code
);
  p_excl_r13: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cfg_valid, loc_valid, err_valid}));

  p_resp_r13: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> (cfg_valid || loc_valid || err_valid));

  p_idle_r13: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !(cfg_valid || loc_valid || err_valid));

  p_misalign_r8: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && ((acc_size == 2'd1 && acc_addr[0]) ||
                   (acc_size[1] && acc_addr[1:0] != 2'b00)))
    |=> (err_valid && err_code == 2'd2));

  p_regnum_r2: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> (!cfg_valid || cfg_reg == $past(acc_addr[11:2])));

  p_wordbe_r7: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_size[1]) |=> (!(cfg_valid || loc_valid) || rsp_be == 4'hF));
endmodule

bind ecam_xlat_top ecam_xlat_chk u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .acc_size(acc_size), .cfg_valid(cfg_valid), .cfg_reg(cfg_reg),
  .rsp_be(rsp_be), .loc_valid(loc_valid), .err_valid(err_valid),
  .err_code(err_code)
);

// File: tb/ecam_xlat_top_tb_top.sv
`timescale 1ns/1ps
module ecam_xlat_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [0:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic [1:0]  acc_size = '0;
  logic        cfg_valid, cfg_write, cfg_type1, loc_valid, err_valid;
  logic [15:0] cfg_bdf;
  logic [9:0]  cfg_reg;
  logic [3:0]  rsp_be;
  logic [19:0] loc_offset;
  logic [1:0]  err_code;

  ecam_xlat_top dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_write(acc_write), .acc_size(acc_size), .cfg_valid(cfg_valid),
    .cfg_write(cfg_write), .cfg_type1(cfg_type1), .cfg_bdf(cfg_bdf),
    .cfg_reg(cfg_reg), .rsp_be(rsp_be), .loc_valid(loc_valid),
    .loc_offset(loc_offset), .err_valid(err_valid), .err_code(err_code)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // kind: 1 cfg, 2 local, 3 error
  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  sz;
    logic        wr;
    logic [1:0]  kind;
    logic [15:0] bdf;
    logic [9:0]  rg;
    logic [3:0]  be;
    logic        t1;
    logic [19:0] off;
    logic [1:0]  err;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{32'h4010_8104, 2'd2, 1'b0, 2'd1, 16'h0108, 10'h041, 4'hF, 1'b0, 20'h0, 2'd0},
    '{32'h4035_A3FE, 2'd1, 1'b1, 2'd1, 16'h035A, 10'h0FF, 4'hC, 1'b1, 20'h0, 2'd0},
    '{32'h4020_0001, 2'd0, 1'b0, 2'd1, 16'h0200, 10'h000, 4'h2, 1'b1, 20'h0, 2'd0},
    '{32'h4000_0010, 2'd2, 1'b1, 2'd2, 16'h0000, 10'h000, 4'hF, 1'b0, 20'h00010, 2'd0},
    '{32'h40FF_FFFC, 2'd2, 1'b0, 2'd1, 16'h0FFF, 10'h3FF, 4'hF, 1'b1, 20'h0, 2'd0},
    '{32'h4100_0000, 2'd2, 1'b0, 2'd3, 16'h0000, 10'h000, 4'h0, 1'b0, 20'h0, 2'd1},
    '{32'h4010_0002, 2'd2, 1'b0, 2'd3, 16'h0000, 10'h000, 4'h0, 1'b0, 20'h0, 2'd2},
    '{32'h400F_FFFF, 2'd0, 1'b0, 2'd2, 16'h0000, 10'h000, 4'h8, 1'b0, 20'hFFFFF, 2'd0},
    '{32'h3FFF_FFFC, 2'd2, 1'b0, 2'd3, 16'h0000, 10'h000, 4'h0, 1'b0, 20'h0, 2'd1},
    '{32'h4010_0001, 2'd1, 1'b1, 2'd3, 16'h0000, 10'h000, 4'h0, 1'b0, 20'h0, 2'd2}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] out_kind();
    return cfg_valid ? 2'd1 : loc_valid ? 2'd2 : err_valid ? 2'd3 : 2'd0;
  endfunction

  task automatic reg_wr(input logic [2:0] sel, input logic idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic access(input logic [31:0] a, input logic [1:0] sz, input logic w);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_size = sz; acc_write = w;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 outputs idle", {cfg_valid, loc_valid, err_valid, err_code, rsp_be}, '0);
    access(32'h4010_8104, 2'd2, 1'b0);
    chk("R1 unconfigured -> UR kind", out_kind(), 2'd3);
    chk("R1 R9 unconfigured code", err_code, 2'd1);

    reg_wr(3'd4, 0, 32'h4000_0000);
    reg_wr(3'd5, 0, 32'h1000_0000);
    reg_wr(3'd6, 0, 32'd16);
    reg_wr(3'd0, 0, 32'h4010_0000);
    reg_wr(3'd1, 0, 32'h0010_0000);
    reg_wr(3'd2, 0, 32'h0000_0000);
    reg_wr(3'd3, 0, 32'h9000_0000);
    reg_wr(3'd0, 1, 32'h4020_0000);
    reg_wr(3'd1, 1, 32'h00E0_0000);
    reg_wr(3'd2, 1, 32'h0000_0001);
    reg_wr(3'd3, 1, 32'h9000_0000);

    // R2 R3 R4 R7 R8 R9 vector table
    for (int i = 0; i < NV; i++) begin
      access(VEC[i].addr, VEC[i].sz, VEC[i].wr);
      chk($sformatf("R13 vec%0d kind", i), out_kind(), VEC[i].kind);
      if (VEC[i].kind == 2'd1) begin
        chk($sformatf("R2 vec%0d bdf", i), cfg_bdf, VEC[i].bdf);
        chk($sformatf("R2 vec%0d reg", i), cfg_reg, VEC[i].rg);
        chk($sformatf("R2 vec%0d write", i), cfg_write, VEC[i].wr);
        chk($sformatf("R3 vec%0d type", i), cfg_type1, VEC[i].t1);
        chk($sformatf("R7 vec%0d be", i), rsp_be, VEC[i].be);
      end else if (VEC[i].kind == 2'd2) begin
        chk($sformatf("R4 vec%0d offset", i), loc_offset, VEC[i].off);
        chk($sformatf("R7 vec%0d be", i), rsp_be, VEC[i].be);
      end else begin
        chk($sformatf("R8 R9 vec%0d code", i), err_code, VEC[i].err);
      end
    end

    // R13: no access -> no response
    @(negedge clk);
    chk("R13 idle after access", {cfg_valid, loc_valid, err_valid}, 3'b000);

    // R10: writes to an enabled region ignored
    reg_wr(3'd0, 1, 32'h5000_0000);
    reg_wr(3'd3, 1, 32'hB000_0000);
    access(32'h4030_0000, 2'd2, 1'b0);
    chk("R10 base write ignored", out_kind(), 2'd1);
    chk("R10 region still type1", cfg_type1, 1'b1);

    // R6 R5: misaligned window base rejects shift
    reg_wr(3'd3, 0, 32'h0000_0000);
    reg_wr(3'd2, 0, 32'hABCD_0000);
    reg_wr(3'd4, 0, 32'h4800_0000);
    reg_wr(3'd3, 0, 32'h9000_0000);
    reg_wr(3'd4, 0, 32'h4000_0000);
    access(32'h4010_8104, 2'd2, 1'b0);
    chk("R6 base align rejects shift (R5 fixed target)", cfg_bdf, 16'hABCD);
    // R6: too many buses rejects shift
    reg_wr(3'd3, 0, 32'h0000_0000);
    reg_wr(3'd6, 0, 32'd300);
    reg_wr(3'd3, 0, 32'h9000_0000);
    reg_wr(3'd6, 0, 32'd16);
    access(32'h4010_F000, 2'd2, 1'b0);
    chk("R6 bus count rejects shift", cfg_bdf, 16'hABCD);
    chk("R5 fixed target type0", cfg_type1, 1'b0);

    // R11: same-cycle write is not seen, next cycle is
    reg_wr(3'd3, 0, 32'h0000_0000);
    reg_wr(3'd2, 0, 32'h0000_0000);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd3; wr_idx = 1'b0; wr_data = 32'h9000_0000;
    acc_valid = 1'b1; acc_addr = 32'h4010_8104; acc_size = 2'd2; acc_write = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R11 same cycle old state", {err_valid, err_code}, 3'b101);
    @(negedge clk);
    acc_valid = 1'b0;
    chk("R11 next cycle enabled", {cfg_valid, cfg_bdf}, {1'b1, 16'h0108});

    // R12: overlap, lowest index wins
    reg_wr(3'd3, 1, 32'h0000_0000);
    reg_wr(3'd0, 1, 32'h4010_0000);
    reg_wr(3'd1, 1, 32'h0010_0000);
    reg_wr(3'd3, 1, 32'h9000_0000);
    access(32'h4010_0000, 2'd2, 1'b0);
    chk("R12 region0 wins type", {cfg_valid, cfg_type1}, 2'b10);
    reg_wr(3'd3, 0, 32'h0000_0000);
    access(32'h4010_0000, 2'd2, 1'b0);
    chk("R12 region1 when region0 off", {cfg_valid, cfg_type1}, 2'b11);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule